// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command-register state machine inside a parallel NOR-style flash model. It watches host write cycles (an address, a data byte and an active-low write-enable strobe that is sampled on the system clock). From these cycles it picks out the unlock-prefixed program and erase sequences and the one-write suspend and resume commands. It latches the program target and issues single-cycle start, suspend and resume requests to a separate engine that carries out the operation. The engine reports completion through a done pulse.

The block tracks six modes: read, program active, erase active, erase suspended, program inside a suspended erase, and a short protect-busy interval. It enters protect-busy when a command touches only protected sectors. Per-sector protect flags arrive as inputs. The erase mask handed to the engine never contains a protected sector. The sector number is the top `SECT_W` bits of the address. The unlock addresses are compared on the low 11 address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), all four request pulses are low, and `progAddr`, `progData` and `eraseMask` are zero.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, followed by one more write, give exactly one `progStart` pulse. When issued from read mode, `mode` becomes 1 (program).
- R3: On that fourth write, `progAddr` holds the address present at the falling edge of `weN`, and `progData` holds the data present at its rising edge.
- R4: In mode 1, an `engDone` pulse returns `mode` to 0 without any further command.
- R5: A write that does not match the next expected byte or address throws the sequence away. The following writes must begin again with the first unlock write. No request is issued and the mode is unchanged.
- R6: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h give one `eraseStart` pulse, `mode` 2 (erase), and `eraseMask` equal to the inverse of `protMask`.
- R7: The same prefix ending in 30h written to any address in sector s gives `eraseMask` with only bit s set, provided sector s is unprotected.
- R8: A program whose target sector is protected, or an erase whose mask would be empty, issues no start. It sets `mode` to 5 (protect-busy) for `BUSY_CYC` cycles, then goes back to the previous mode with the latched outputs unchanged.
- R9: B0h written in mode 2 gives one `suspendReq` pulse and `mode` 3 (suspended). B0h in any other mode has no effect. A later B0h after a resume suspends again.
- R10: 30h written in mode 3 (with no sequence in progress) gives one `resumeReq` pulse and `mode` 2. 30h in read or erase mode has no effect.
- R11: In mode 3, a full program sequence gives `progStart` and `mode` 4, and `engDone` then returns `mode` to 3. An erase sequence in mode 3 is not accepted.
- R12: Writes during modes 1, 4 and 5, and any write other than B0h during mode 2, produce no request and no mode change. At most one request pulse is high in any cycle.
- R13: If `engDone` arrives in the same cycle as a decoded suspend write in mode 2, completion wins. `mode` goes to 0 and no `suspendReq` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Write-cycle address |
| busData | input | DATA_W | Write-cycle data |
| weN | input | 1 | Active-low write strobe, synchronous to clk |
| protMask | input | NUM_SECT | Per-sector protect flags, 1 = protected |
| engDone | input | 1 | Engine completion pulse |
| progStart | output | 1 | Program start request pulse |
| eraseStart | output | 1 | Erase start request pulse |
| suspendReq | output | 1 | Erase suspend request pulse |
| resumeReq | output | 1 | Erase resume request pulse |
| progAddr | output | ADDR_W | Latched program address |
| progData | output | DATA_W | Latched program data |
| eraseMask | output | NUM_SECT | Sectors selected for erase |
| mode | output | 3 | Current mode code (0..5 as above) |

## Verification
Engine completion and a decoded suspend write can reach the mode logic in the same cycle. If the wrong one took priority, the model would either hang suspended with nothing running, or miss the completion. The bench times an `engDone` pulse onto the exact cycle in which the B0h write is decoded, one clock after the strobe's rising edge is seen. It then expects read mode and an unchanged suspend-request count. Separate scenarios place the same B0h write with no completion pending, to show that suspend itself still works.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_READ      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP      = 3'd3,
    MODE_SUSP_PROG = 3'd4,
    MODE_PROT_BUSY = 3'd5
  } modeE;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic latchProg;
    logic latchErase;
    logic eraseChip;
    logic startBusy;
  } ctlStrobeS;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ESETUP  = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  localparam int UNLOCK_W = 11;
  localparam logic [UNLOCK_W-1:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [UNLOCK_W-1:0] UNLOCK_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int SECT_W   = 3,
  parameter int BUSY_CYC = 8,
  localparam int NUM_SECT = 1 << SECT_W,
  localparam int CNT_W    = $clog2(BUSY_CYC + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busData,
  input  logic                weN,
  input  logic [NUM_SECT-1:0] protMask,
  input  ctlStrobeS           strobe,
  output logic                wrStb,
  output logic [7:0]          cmdByte,
  output logic                atAddrA,
  output logic                atAddrB,
  output logic                sectFree,
  output logic                anyFree,
  output logic                busyDone,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [DATA_W-1:0]   progData,
  output logic [NUM_SECT-1:0] eraseMask
);

  logic                weD;
  logic                fallEv, riseEv;
  logic [ADDR_W-1:0]   wrAddr;
  logic [DATA_W-1:0]   wrData;
  logic [SECT_W-1:0]   wrSect;
  logic [NUM_SECT-1:0] sectHit;
  logic [CNT_W-1:0]    busyCnt;

  assign fallEv = weD & ~weN;
  assign riseEv = ~weD & weN;

  // Address captured on the falling strobe edge, data on the rising one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weD    <= 1'b1;
      wrAddr <= '0;
      wrData <= '0;
      wrStb  <= 1'b0;
    end else begin
      weD   <= weN;
      wrStb <= riseEv;
      if (fallEv) wrAddr <= busAddr;
      if (riseEv) wrData <= busData;
    end
  end

  assign cmdByte = wrData[7:0];
  assign atAddrA = (wrAddr[UNLOCK_W-1:0] == UNLOCK_ADDR_A);
  assign atAddrB = (wrAddr[UNLOCK_W-1:0] == UNLOCK_ADDR_B);
  assign wrSect  = wrAddr[ADDR_W-1 -: SECT_W];

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    assign sectHit[g] = (wrSect == SECT_W'(g));
  end

  assign sectFree = |(sectHit & ~protMask);
  assign anyFree  = |(~protMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr  <= '0;
      progData  <= '0;
      eraseMask <= '0;
    end else begin
      if (strobe.latchProg) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (strobe.latchErase)
        eraseMask <= strobe.eraseChip ? ~protMask : (sectHit & ~protMask);
    end
  end

  // Protect-busy interval timer
  always_ff @(posedge clk) begin
    if (!rstN)                 busyCnt <= '0;
    else if (strobe.startBusy) busyCnt <= CNT_W'(BUSY_CYC - 1);
    else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
  end

  assign busyDone = (busyCnt == '0);

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStb,
  input  logic [7:0] cmdByte,
  input  logic      atAddrA,
  input  logic      atAddrB,
  input  logic      sectFree,
  input  logic      anyFree,
  input  logic      busyDone,
  input  logic      engDone,
  output ctlStrobeS strobe,
  output logic      progStart,
  output logic      eraseStart,
  output logic      suspendReq,
  output logic      resumeReq,
  output modeE      modeQ
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_ARM, ST_E1, ST_E2, ST_E3
  } stepE;

  stepE stepQ, stepN;
  modeE modeN, retQ, retN;
  logic progN, eraseN, suspN, resN;

  always_comb begin
    modeN  = modeQ;
    stepN  = stepQ;
    retN   = retQ;
    strobe = '0;
    progN  = 1'b0;
    eraseN = 1'b0;
    suspN  = 1'b0;
    resN   = 1'b0;
    case (modeQ)
      MODE_PROT_BUSY: begin
        stepN = ST_IDLE;
        if (busyDone) modeN = retQ;
      end
      MODE_PROG: begin
        stepN = ST_IDLE;
        if (engDone) modeN = MODE_READ;
      end
      MODE_SUSP_PROG: begin
        stepN = ST_IDLE;
        if (engDone) modeN = MODE_SUSP;
      end
      MODE_ERASE: begin
        stepN = ST_IDLE;
        // completion takes priority over a same-cycle suspend
        if (engDone) modeN = MODE_READ;
        else if (wrStb && cmdByte == CMD_SUSPEND) begin
          modeN = MODE_SUSP;
          suspN = 1'b1;
        end
      end
      default: begin
        if (wrStb) begin
          stepN = ST_IDLE;
          case (stepQ)
            ST_IDLE: begin
              if (atAddrA && cmdByte == CMD_UNLOCK1) stepN = ST_U1;
              else if (modeQ == MODE_SUSP && cmdByte == CMD_RESUME) begin
                modeN = MODE_ERASE;
                resN  = 1'b1;
              end
            end
            ST_U1: if (atAddrB && cmdByte == CMD_UNLOCK2) stepN = ST_U2;
            ST_U2: begin
              if (atAddrA && cmdByte == CMD_PROGRAM) stepN = ST_ARM;
              else if (atAddrA && cmdByte == CMD_ESETUP && modeQ == MODE_READ)
                stepN = ST_E1;
            end
            ST_ARM: begin
              if (sectFree) begin
                strobe.latchProg = 1'b1;
                progN = 1'b1;
                modeN = (modeQ == MODE_READ) ? MODE_PROG : MODE_SUSP_PROG;
              end else begin
                strobe.startBusy = 1'b1;
                retN  = modeQ;
                modeN = MODE_PROT_BUSY;
              end
            end
            ST_E1: if (atAddrA && cmdByte == CMD_UNLOCK1) stepN = ST_E2;
            ST_E2: if (atAddrB && cmdByte == CMD_UNLOCK2) stepN = ST_E3;
            ST_E3: begin
              if ((atAddrA && cmdByte == CMD_CHIP) || cmdByte == CMD_SECTOR) begin
                if ((cmdByte == CMD_CHIP) ? anyFree : sectFree) begin
                  strobe.latchErase = 1'b1;
                  strobe.eraseChip  = (cmdByte == CMD_CHIP);
                  eraseN = 1'b1;
                  modeN  = MODE_ERASE;
                end else begin
                  strobe.startBusy = 1'b1;
                  retN  = modeQ;
                  modeN = MODE_PROT_BUSY;
                end
              end
            end
            default: stepN = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_READ;
      stepQ      <= ST_IDLE;
      retQ       <= MODE_READ;
      progStart  <= 1'b0;
      eraseStart <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
    end else begin
      modeQ      <= modeN;
      stepQ      <= stepN;
      retQ       <= retN;
      progStart  <= progN;
      eraseStart <= eraseN;
      suspendReq <= suspN;
      resumeReq  <= resN;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int SECT_W   = 3,
  parameter int BUSY_CYC = 8,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busData,
  input  logic                weN,
  input  logic [NUM_SECT-1:0] protMask,
  input  logic                engDone,
  output logic                progStart,
  output logic                eraseStart,
  output logic                suspendReq,
  output logic                resumeReq,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [DATA_W-1:0]   progData,
  output logic [NUM_SECT-1:0] eraseMask,
  output logic [2:0]          mode
);

  ctlStrobeS  strobe;
  logic       wrStb, atAddrA, atAddrB, sectFree, anyFree, busyDone;
  logic [7:0] cmdByte;
  modeE       modeQ;

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .BUSY_CYC(BUSY_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .weN(weN),
    .protMask(protMask), .strobe(strobe), .wrStb(wrStb), .cmdByte(cmdByte),
    .atAddrA(atAddrA), .atAddrB(atAddrB), .sectFree(sectFree), .anyFree(anyFree),
    .busyDone(busyDone), .progAddr(progAddr), .progData(progData),
    .eraseMask(eraseMask)
  );

  flash_cmd_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .cmdByte(cmdByte),
    .atAddrA(atAddrA), .atAddrB(atAddrB), .sectFree(sectFree), .anyFree(anyFree),
    .busyDone(busyDone), .engDone(engDone), .strobe(strobe),
    .progStart(progStart), .eraseStart(eraseStart), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .modeQ(modeQ)
  );

  assign mode = modeQ;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_SECT-1:0] protMask,
  input logic                engDone,
  input logic                progStart,
  input logic                eraseStart,
  input logic                suspendReq,
  input logic                resumeReq,
  input logic [NUM_SECT-1:0] eraseMask,
  input logic [2:0]          mode
);

  p_one_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, eraseStart, suspendReq, resumeReq}));

  p_prog_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (mode == 3'd1 || mode == 3'd4));

  p_erase_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> ((eraseMask & $past(protMask)) == '0 && eraseMask != '0));

  p_suspend_r9: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> ($past(mode) == 3'd2 && mode == 3'd3));

  p_resume_r10: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> ($past(mode) == 3'd3 && mode == 3'd2));

  p_prog_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && engDone) |=> mode == 3'd0);

  p_prog_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && !engDone) |=> mode == 3'd1);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rstN(rstN), .protMask(protMask), .engDone(engDone),
  .progStart(progStart), .eraseStart(eraseStart), .suspendReq(suspendReq),
  .resumeReq(resumeReq), .eraseMask(eraseMask), .mode(mode)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int ADDR_W = 18;
  localparam int DATA_W = 8;
  localparam int NS = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busData = '0;
  logic              weN = 1'b1;
  logic [NS-1:0]     protMask = '0;
  logic              engDone = 1'b0;
  logic              progStart, eraseStart, suspendReq, resumeReq;
  logic [ADDR_W-1:0] progAddr;
  logic [DATA_W-1:0] progData;
  logic [NS-1:0]     eraseMask;
  logic [2:0]        mode;

  int checks = 0, errors = 0;
  int progCnt = 0, eraseCnt = 0, suspCnt = 0, resCnt = 0;
  int pulseSeen = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .weN(weN),
    .protMask(protMask), .engDone(engDone), .progStart(progStart),
    .eraseStart(eraseStart), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .progAddr(progAddr), .progData(progData), .eraseMask(eraseMask), .mode(mode)
  );

  always @(negedge clk) if (rstN) begin
    if (progStart)  progCnt++;
    if (eraseStart) eraseCnt++;
    if (suspendReq) suspCnt++;
    if (resumeReq)  resCnt++;
    if (progStart | eraseStart | suspendReq | resumeReq) pulseSeen++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] sAddr(input int s, input logic [14:0] off);
    return {3'(s), off};
  endfunction

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busData = d; weN = 1'b0;
    @(negedge clk);
    @(negedge clk); weN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Address and data change while the strobe is low
  task automatic splitWrite(input logic [ADDR_W-1:0] aFall, input logic [ADDR_W-1:0] aRise,
                            input logic [7:0] dFall, input logic [7:0] dRise);
    @(negedge clk); busAddr = aFall; busData = dFall; weN = 1'b0;
    @(negedge clk); busAddr = aRise; busData = dRise;
    @(negedge clk); weN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    busWrite(18'h00555, 8'hAA);
    busWrite(18'h002AA, 8'h55);
  endtask

  task automatic engPulse();
    @(negedge clk); engDone = 1'b1;
    @(negedge clk); engDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic eraseSeq(input logic [ADDR_W-1:0] lastA, input logic [7:0] lastD);
    unlock(); busWrite(18'h00555, 8'h80);
    unlock(); busWrite(lastA, lastD);
  endtask

  task automatic t_reset();
    check("R1 mode", mode, 0);
    check("R1 pulses", {progStart, eraseStart, suspendReq, resumeReq}, 0);
    check("R1 progAddr", progAddr, 0);
    check("R1 progData", progData, 0);
    check("R1 eraseMask", eraseMask, 0);
  endtask

  task automatic t_program();
    int p0 = progCnt;
    unlock(); busWrite(18'h00555, 8'hA0);
    splitWrite(18'h0A123, 18'h3FFFF, 8'h11, 8'h5C);
    check("R2 progStart count", progCnt - p0, 1);
    check("R2 mode program", mode, 1);
    check("R3 addr at fall", progAddr, 18'h0A123);
    check("R3 data at rise", progData, 8'h5C);
    unlock(); busWrite(18'h00555, 8'hA0); busWrite(18'h01000, 8'h77);
    check("R12 writes in program ignored", progCnt - p0, 1);
    check("R12 mode held", mode, 1);
    engPulse();
    check("R4 back to read", mode, 0);
  endtask

  task automatic t_broken();
    int p0 = pulseSeen;
    busWrite(18'h00555, 8'hAA);
    busWrite(18'h002AB, 8'h55);
    busWrite(18'h00555, 8'hA0);
    busWrite(18'h04000, 8'h12);
    check("R5 no request", pulseSeen - p0, 0);
    check("R5 mode read", mode, 0);
    check("R5 progAddr kept", progAddr, 18'h0A123);
  endtask

  task automatic t_chip_suspend();
    int e0 = eraseCnt, s0 = suspCnt, r0 = resCnt, p0 = progCnt;
    protMask = 8'h05;
    eraseSeq(18'h00555, 8'h10);
    check("R6 eraseStart", eraseCnt - e0, 1);
    check("R6 mode erase", mode, 2);
    check("R6 mask", eraseMask, 8'hFA);
    busWrite(18'h00555, 8'h30);
    check("R10 resume ignored in erase", resCnt - r0, 0);
    check("R12 mode erase held", mode, 2);
    busWrite(18'h00000, 8'hB0);
    check("R9 suspend", suspCnt - s0, 1);
    check("R9 mode susp", mode, 3);
    busWrite(18'h00000, 8'h30);
    check("R10 resume", resCnt - r0, 1);
    check("R10 mode erase", mode, 2);
    busWrite(18'h00000, 8'hB0);
    check("R9 re-suspend", suspCnt - s0, 2);
    check("R9 mode susp again", mode, 3);
    unlock(); busWrite(18'h00555, 8'hA0); busWrite(sAddr(5, 15'h0040), 8'h3C);
    check("R11 prog in suspend", progCnt - p0, 1);
    check("R11 mode susp-prog", mode, 4);
    check("R11 progAddr", progAddr, sAddr(5, 15'h0040));
    engPulse();
    check("R11 back to susp", mode, 3);
    eraseSeq(18'h00555, 8'h10);
    check("R11 erase in suspend refused", eraseCnt - e0, 1);
    check("R11 mode susp kept", mode, 3);
    busWrite(18'h00000, 8'h30);
    check("R10 mode erase after resume", mode, 2);
    engPulse();
    check("R4 erase done read", mode, 0);
    busWrite(18'h00000, 8'hB0);
    check("R9 B0 in read ignored", suspCnt - s0, 2);
    check("R9 mode read", mode, 0);
    busWrite(18'h00000, 8'h30);
    check("R10 30 in read ignored", resCnt - r0, 2);
  endtask

  task automatic t_sector();
    int e0 = eraseCnt;
    eraseSeq(sAddr(6, 15'h1234), 8'h30);
    check("R7 eraseStart", eraseCnt - e0, 1);
    check("R7 mask sector 6", eraseMask, 8'h40);
    engPulse();
    check("R7 mode read", mode, 0);
  endtask

  task automatic t_protect();
    int e0 = eraseCnt, p0 = progCnt;
    unlock(); busWrite(18'h00555, 8'hA0); busWrite(sAddr(2, 15'h0010), 8'h99);
    check("R8 prog busy mode", mode, 5);
    repeat (12) @(negedge clk);
    check("R8 prog busy over", mode, 0);
    check("R8 no progStart", progCnt - p0, 0);
    check("R8 progData kept", progData, 8'h3C);
    eraseSeq(sAddr(0, 15'h0000), 8'h30);
    check("R8 erase busy mode", mode, 5);
    repeat (12) @(negedge clk);
    check("R8 erase busy over", mode, 0);
    check("R8 no eraseStart", eraseCnt - e0, 0);
    check("R8 mask kept", eraseMask, 8'h40);
  endtask

  task automatic t_coincide();
    int s0 = suspCnt;
    eraseSeq(sAddr(7, 15'h0000), 8'h30);
    check("R13 erase running", mode, 2);
    @(negedge clk); busAddr = '0; busData = 8'hB0; weN = 1'b0;
    @(negedge clk);
    @(negedge clk); weN = 1'b1;
    @(negedge clk); engDone = 1'b1;
    @(negedge clk); engDone = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 completion wins", mode, 0);
    check("R13 no suspendReq", suspCnt - s0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_broken();
    t_chip_suspend();
    t_sector();
    t_protect();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule